// File: doc/BRIEF.md
# Packet Fragment Capture Mailbox

This block takes fragments from a byte-wide packet stream and parks one of them at a time in a buffer that a processor can read through a small register port. Each fragment carries a logical channel identifier and five status indications (start of packet, end of packet, address parity error, data parity error, packet error). These are taken from side-band inputs on the first byte. The block counts the bytes it actually received, so the short tail fragment of a packet reports its true length.

When the last byte of a fragment is accepted, the buffer is handed to the processor. A data-available flag goes high and a single-cycle event is sent to an interrupt controller. From then on the stream is held off with ready low, and nothing in the buffer changes. The processor reads the header words and the payload bytes over a registered read port. It then writes zero to the available flag, which returns the buffer to the stream side.

Top module: `frag_capture_mbox`

## Requirements
- R1: After reset, `avail_o` and `event_o` are 0, `s_ready_o` is 1 and `rd_data_o` is 0.
- R2: Payload byte k of the held fragment reads back at read address 3+k, and the length word holds the number of bytes received.
- R3: The clock edge that accepts the byte with `s_last_i` set raises `avail_o`. `event_o` is 1 for exactly that cycle. `avail_o` never rises without such a byte.
- R4: While `avail_o` is 1, `s_ready_o` is 0. Stream inputs presented in that time leave every readable word unchanged.
- R5: A control write with `ctrl_avail_i`=0 clears `avail_o` at the next edge. A control write with value 1 has no effect. A write of 0 while the buffer is idle raises no event.
- R6: The identifier and all five flag inputs are sampled on the first byte of a fragment. Changes on later bytes are ignored.
- R7: A fragment of more than 256 bytes keeps only its first 256 bytes, reports length 256 and has the packet-error bit forced to 1. A fragment of exactly 256 bytes is not marked.
- R8: Read map: address 0 is the flags word, 1 the length word, 2 the identifier word, and 3 to 258 the payload bytes. Any higher address reads 0. `rd_data_o` updates one edge after `rd_en_i` and holds otherwise.
- R9: The flags word has start of packet at bit 0, end of packet at bit 1, address parity error at bit 2, data parity error at bit 3 and packet error at bit 4. All other bits read 0. A one-byte fragment is stored with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream ready, low while the buffer is held |
| s_data_i | input | 8 | Stream payload byte |
| s_last_i | input | 1 | Marks the final byte of a fragment |
| s_id_i | input | ID_W (6) | Logical channel identifier, sampled on first byte |
| s_sop_i | input | 1 | Start-of-packet indication |
| s_eop_i | input | 1 | End-of-packet indication |
| s_apar_err_i | input | 1 | Address parity error indication |
| s_dpar_err_i | input | 1 | Data parity error indication |
| s_pkt_err_i | input | 1 | Packet error indication |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W (9) | Register read address |
| rd_data_o | output | WORD_W (16) | Registered read data |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_avail_i | input | 1 | Value written to the available flag |
| avail_o | output | 1 | Data-available flag |
| event_o | output | 1 | One-cycle capture event |

## Verification
Two things can happen in the same cycle. The processor writes zero to release the buffer and reads the length word, and at that moment a new fragment's first byte is already waiting on the stream. The bench does all three in one cycle. The read must return the old length. The waiting byte must not be taken at that edge, because ready is still low there. It must be taken at the next edge, and the fragment that follows is checked for the correct length, so a byte taken twice or lost would show. A scoreboard queue records the expected value of every read and compares it one cycle later.

// File: rtl/frag_cap_pkg.sv
package frag_cap_pkg;
  typedef struct packed {
    logic pkt_err;
    logic dpar_err;
    logic apar_err;
    logic eop;
    logic sop;
  } frag_flags_t;

  localparam int FLAG_W     = 5;
  localparam int HDR_SLOTS  = 3;
  localparam int SLOT_FLAGS = 0;
  localparam int SLOT_LEN   = 1;
  localparam int SLOT_ID    = 2;
endpackage

// File: rtl/frag_cap_ctrl.sv
module frag_cap_ctrl
  import frag_cap_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int ID_W      = 6,
  parameter int LEN_W     = 9,
  parameter int IDX_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  input  logic [ID_W-1:0]  s_id_i,
  input  frag_flags_t      s_flags_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_avail_i,
  output logic             s_ready_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             avail_o,
  output logic             event_o,
  output logic [LEN_W-1:0] len_o,
  output logic [ID_W-1:0]  id_o,
  output frag_flags_t      flags_o
);
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [ID_W-1:0]  id_sh_q, id_q, cur_id;
  frag_flags_t      flg_sh_q, flg_q, cur_flg, fin_flg;
  logic             avail_q, evt_q;
  logic             beat, first, sat, release_req;

  assign beat        = s_valid_i && !avail_q;
  assign first       = (cnt_q == '0);
  assign sat         = (cnt_q == LEN_W'(MAX_BYTES));
  assign release_req = avail_q && ctrl_we_i && !ctrl_avail_i;

  // side-band is taken from the first byte only
  always_comb begin
    cur_id  = first ? s_id_i : id_sh_q;
    cur_flg = first ? s_flags_i : flg_sh_q;
    fin_flg = cur_flg;
    fin_flg.pkt_err = cur_flg.pkt_err | sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      len_q    <= '0;
      id_sh_q  <= '0;
      id_q     <= '0;
      flg_sh_q <= '0;
      flg_q    <= '0;
      avail_q  <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (beat) begin
        if (first) begin
          id_sh_q  <= s_id_i;
          flg_sh_q <= s_flags_i;
        end
        if (s_last_i) begin
          cnt_q   <= '0;
          len_q   <= sat ? LEN_W'(MAX_BYTES) : cnt_q + 1'b1;
          id_q    <= cur_id;
          flg_q   <= fin_flg;
          avail_q <= 1'b1;
          evt_q   <= 1'b1;
        end else if (!sat) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (release_req) begin
        avail_q <= 1'b0;
      end
    end
  end

  assign s_ready_o = !avail_q;
  assign wr_en_o   = beat && !sat;
  assign wr_idx_o  = cnt_q[IDX_W-1:0];
  assign avail_o   = avail_q;
  assign event_o   = evt_q;
  assign len_o     = len_q;
  assign id_o      = id_q;
  assign flags_o   = flg_q;
endmodule

// File: rtl/frag_cap_store.sv
module frag_cap_store #(
  parameter int MAX_BYTES = 256,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic [BYTE_W-1:0] mem_q [MAX_BYTES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_byte_o = mem_q[rd_idx_i];
endmodule

// File: rtl/frag_cap_rdport.sv
module frag_cap_rdport
  import frag_cap_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int BYTE_W    = 8,
  parameter int ID_W      = 6,
  parameter int LEN_W     = 9,
  parameter int IDX_W     = 8,
  parameter int ADDR_W    = 9,
  parameter int WORD_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  frag_flags_t       flags_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] DataLo = ADDR_W'(HDR_SLOTS);
  localparam logic [ADDR_W-1:0] DataHi = ADDR_W'(HDR_SLOTS + MAX_BYTES);

  logic [ADDR_W-1:0] off;
  logic [FLAG_W-1:0] flag_bits;
  logic [WORD_W-1:0] word_d, rd_q;

  assign off       = rd_addr_i - DataLo;
  assign rd_idx_o  = off[IDX_W-1:0];
  assign flag_bits = flags_i;

  always_comb begin
    word_d = '0;
    if (rd_addr_i == ADDR_W'(SLOT_FLAGS))   word_d = WORD_W'(flag_bits);
    else if (rd_addr_i == ADDR_W'(SLOT_LEN)) word_d = WORD_W'(len_i);
    else if (rd_addr_i == ADDR_W'(SLOT_ID))  word_d = WORD_W'(id_i);
    else if (rd_addr_i >= DataLo && rd_addr_i < DataHi) word_d = WORD_W'(byte_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= word_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/frag_capture_mbox.sv
module frag_capture_mbox
  import frag_cap_pkg::*;
#(
  parameter int MAX_BYTES = 256,
  parameter int BYTE_W    = 8,
  parameter int ID_W      = 6,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = $clog2(MAX_BYTES + HDR_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  input  logic [ID_W-1:0]   s_id_i,
  input  logic              s_sop_i,
  input  logic              s_eop_i,
  input  logic              s_apar_err_i,
  input  logic              s_dpar_err_i,
  input  logic              s_pkt_err_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              ctrl_we_i,
  input  logic              ctrl_avail_i,
  output logic              avail_o,
  output logic              event_o
);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = $clog2(MAX_BYTES);

  frag_flags_t      s_flags, flags;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [LEN_W-1:0] len;
  logic [ID_W-1:0]  id;
  logic [BYTE_W-1:0] rd_byte;

  always_comb begin
    s_flags.sop      = s_sop_i;
    s_flags.eop      = s_eop_i;
    s_flags.apar_err = s_apar_err_i;
    s_flags.dpar_err = s_dpar_err_i;
    s_flags.pkt_err  = s_pkt_err_i;
  end

  frag_cap_ctrl #(
    .MAX_BYTES(MAX_BYTES), .ID_W(ID_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .s_valid_i, .s_last_i, .s_id_i,
    .s_flags_i(s_flags), .ctrl_we_i, .ctrl_avail_i, .s_ready_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .avail_o, .event_o,
    .len_o(len), .id_o(id), .flags_o(flags)
  );

  frag_cap_store #(
    .MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(s_data_i),
    .rd_idx_i(rd_idx), .rd_byte_o(rd_byte)
  );

  frag_cap_rdport #(
    .MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .ID_W(ID_W), .LEN_W(LEN_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_rdport (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .flags_i(flags), .len_i(len),
    .id_i(id), .byte_i(rd_byte), .rd_idx_o(rd_idx), .rd_data_o
  );
endmodule

// File: rtl/frag_cap_chk.sv
module frag_cap_chk #(
  parameter int MAX_BYTES = 256,
  parameter int ADDR_W    = 9,
  parameter int WORD_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic              s_last_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              ctrl_we_i,
  input logic              ctrl_avail_i,
  input logic              avail_o,
  input logic              event_o
);
  // R4
  busy_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o |-> !s_ready_o);
  // R4
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> s_ready_o);
  // R3
  event_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $rose(avail_o));
  // R3
  rise_has_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> event_o);
  // R3
  set_needs_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avail_o && !(s_valid_i && s_ready_o && s_last_i)) |=> !avail_o);
  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && ctrl_we_i && !ctrl_avail_i) |=> !avail_o);
  // R5
  hold_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !(ctrl_we_i && !ctrl_avail_i)) |=> avail_o);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i >= ADDR_W'(MAX_BYTES + 3)) |=> (rd_data_o == '0));
  // R8
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind frag_capture_mbox frag_cap_chk #(
  .MAX_BYTES(MAX_BYTES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i, .rst_ni, .s_valid_i, .s_ready_o, .s_last_i, .rd_en_i, .rd_addr_i,
  .rd_data_o, .ctrl_we_i, .ctrl_avail_i, .avail_o, .event_o
);

// File: tb/frag_capture_mbox_bench.sv
module frag_capture_mbox_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        s_valid_i = 1'b0, s_ready_o, s_last_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic [5:0]  s_id_i = '0;
  logic        s_sop_i = 1'b0, s_eop_i = 1'b0, s_apar_err_i = 1'b0;
  logic        s_dpar_err_i = 1'b0, s_pkt_err_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [8:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        ctrl_we_i = 1'b0, ctrl_avail_i = 1'b0;
  logic        avail_o, event_o;
  logic        rd_en_d = 1'b0;

  int errors = 0, checks = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk_i = ~clk_i;

  frag_capture_mbox u_frag_capture_mbox (.*);

  always @(posedge clk_i) rd_en_d <= rd_en_i;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result one edge after its request
  always @(negedge clk_i) begin
    if (rd_en_d && exp_q.size() > 0) begin
      check(tag_q.pop_front(), int'(rd_data_o), exp_q.pop_front());
    end
  end

  function automatic logic [7:0] pbyte(int seed, int i);
    return 8'((seed * 7 + i * 13) & 255);
  endfunction

  task automatic rd(int addr, int exp, string tag);
    rd_en_i   = 1'b1;
    rd_addr_i = 9'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // entered and left at a negedge; returns just after the last byte is taken
  task automatic send(int n, int id, logic [4:0] fl, int seed, bit perturb);
    for (int i = 0; i < n; i++) begin
      s_valid_i    = 1'b1;
      s_data_i     = pbyte(seed, i);
      s_last_i     = (i == n - 1);
      s_id_i       = (perturb && i > 0) ? ~6'(id) : 6'(id);
      {s_pkt_err_i, s_dpar_err_i, s_apar_err_i, s_eop_i, s_sop_i} =
        (perturb && i > 0) ? ~fl : fl;
      while (!s_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  task automatic release_buf();
    ctrl_we_i = 1'b1; ctrl_avail_i = 1'b0;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog R3 act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 avail", int'(avail_o), 0);
    check("R1 ready", int'(s_ready_o), 1);
    check("R1 event", int'(event_o), 0);
    check("R1 rd_data", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // fragment A: 8 bytes, side-band disturbed after byte 0 (R6)
    send(8, 5, 5'b00001, 1, 1'b1);
    check("R3 avail rise", int'(avail_o), 1);
    check("R3 event pulse", int'(event_o), 1);
    @(negedge clk_i);
    check("R3 event single", int'(event_o), 0);
    check("R4 ready low", int'(s_ready_o), 0);
    // stream pushes while owned by processor (R4)
    s_valid_i = 1'b1; s_last_i = 1'b1; s_data_i = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R4 ready held low", int'(s_ready_o), 0);
    end
    s_valid_i = 1'b0; s_last_i = 1'b0;
    check("R3 no second event", int'(event_o), 0);
    rd(0, 'h01, "R6 R9 flags A");
    rd(1, 8, "R2 length A");
    rd(2, 5, "R6 id A");
    for (int i = 0; i < 8; i++) rd(3 + i, int'(pbyte(1, i)), "R2 R4 byte A");
    rd(259, 0, "R8 past end");
    rd(300, 0, "R8 unmapped");

    // R5: writing 1 has no effect
    ctrl_we_i = 1'b1; ctrl_avail_i = 1'b1;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    check("R5 write one ignored", int'(avail_o), 1);

    // collision: release + length read + waiting first byte in one cycle
    ctrl_we_i = 1'b1; ctrl_avail_i = 1'b0;
    s_valid_i = 1'b1; s_data_i = pbyte(2, 0); s_last_i = 1'b1;
    rd(1, 8, "R8 length read during release");
    ctrl_we_i = 1'b0;
    check("R5 released", int'(avail_o), 0);
    check("R5 ready back", int'(s_ready_o), 1);
    check("R3 not yet taken", int'(event_o), 0);

    // fragment B: one byte
    send(1, 63, 5'b01011, 2, 1'b0);
    check("R3 event B", int'(event_o), 1);
    rd(1, 1, "R9 length one");
    rd(0, 'h0B, "R9 flags B");
    rd(2, 63, "R6 id B");
    rd(3, int'(pbyte(2, 0)), "R2 byte B");
    release_buf();

    // R5: release while idle
    release_buf();
    check("R5 idle write avail", int'(avail_o), 0);
    check("R5 idle write event", int'(event_o), 0);

    // fragment C: 300 bytes, truncated (R7)
    send(300, 17, 5'b00100, 3, 1'b0);
    check("R7 event C", int'(event_o), 1);
    rd(0, 'h14, "R7 flags forced pkt err");
    rd(1, 256, "R7 length capped");
    rd(2, 17, "R6 id C");
    rd(3, int'(pbyte(3, 0)), "R7 byte 0");
    rd(103, int'(pbyte(3, 100)), "R7 byte 100");
    rd(258, int'(pbyte(3, 255)), "R7 byte 255");
    release_buf();

    // fragment D: exactly 256 bytes, no forced error (R7)
    send(256, 40, 5'b00010, 4, 1'b0);
    rd(0, 'h02, "R7 R9 flags exact 256");
    rd(1, 256, "R7 length exact 256");
    rd(258, int'(pbyte(4, 255)), "R2 last byte D");
    release_buf();

    repeat (3) @(negedge clk_i);
    check("R8 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule